// File: doc/BRIEF.md
# Zero-Overhead SEC-DED Codec for Packed Weight Groups

This block protects a group of eight signed 8-bit neural-network weights held in one 64-bit memory word, without widening the word. Seven of the weights, in lanes 0 to 6, are required to fit in a narrower signed range. Their top bit then only repeats bit 6 and carries no information. The encoder drops those seven redundant bits and stores check bits in their place. The check bits form a single-error-correcting, double-error-detecting code over the 57 bits that remain: the low 7 bits of lanes 0 to 6 plus all 8 bits of lane 7. Lane 7 is the one weight allowed to use the full 8-bit range.

The decoder takes a stored word and recomputes the code. It repairs any single flipped bit and reports any two flipped bits. It then rebuilds the seven narrow weights by copying bit 6 into bit 7. Both directions have a registered output with one cycle of latency, and each output is qualified by its own valid strobe. The encoder also reports when a narrow-lane weight would lose information by being packed.

Top module: `weightGroupEcc`

## Requirements
- R1: A word presented with `encValidIn` high appears on `encWordOut` with `encValidOut` high exactly one clock later, and `encValidOut` is low in every cycle that does not follow an `encValidIn` cycle.
- R2: In the encoded word, lane 7 (bits 63:56) equals the lane-7 input weight unchanged, and bits 8i+6..8i hold the low 7 bits of input lane i, for i = 0..6.
- R3: Every encoded word has even parity across all 64 bits. Bit 8i+7 carries check bit i: bits 0..5 are Hamming parity bits and bit 6 is the overall parity bit.
- R4: `encRangeErr` is high with the encoded word exactly when at least one input weight in lanes 0..6 lies outside [-64, 63], that is when its bit 7 differs from its bit 6. Lane 7 never raises the flag.
- R5: Decoding an unmodified encoded word returns the original eight weights one clock after `decValidIn`, with `decValidOut` high and both error flags low.
- R6: A word with any single bit flipped, at any of the 64 positions, decodes to the original weights with `decCorrected` high and `decUncorrectable` low.
- R7: A word with two distinct bits flipped decodes with `decUncorrectable` high and `decCorrected` low.
- R8: In every decoded result, bit 7 of lanes 0..6 equals bit 6 of the same lane.
- R9: While `rstN` is low and after reset, both valid outputs, all flags and both data outputs are zero until the first valid input.
- R10: When a valid input is low, the matching outputs (word, weights and flags) keep their previous values.
- R11: `decCorrected` and `decUncorrectable` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| encValidIn | input | 1 | Encode request strobe |
| encWeightsIn | input | 64 | Eight signed weights, lane i at bits 8i+7..8i |
| encValidOut | output | 1 | Encoded word valid |
| encWordOut | output | 64 | Encoded memory word |
| encRangeErr | output | 1 | A narrow-lane weight was out of range |
| decValidIn | input | 1 | Decode request strobe |
| decWordIn | input | 64 | Stored memory word to check |
| decValidOut | output | 1 | Decoded weights valid |
| decWeightsOut | output | 64 | Corrected, sign-extended weights |
| decCorrected | output | 1 | A single error was found and repaired |
| decUncorrectable | output | 1 | A double error was detected |

## Verification
The bench builds the block with its default parameters: eight lanes of eight bits. That gives a 64-bit word with 57 information bits, six Hamming bits and one overall bit. At this size the bench can flip each of the 64 bit positions in turn for several weight patterns. The flips cover data bits, Hamming bits and the overall parity bit, so every syndrome value and the zero-syndrome parity-only case are reached. Double-bit flips across varied position pairs, range checks at the -64/63 boundaries and at lane 7's extremes, and round trips of encoded words complete the picture.

// File: rtl/weightEccPkg.sv
package weightEccPkg;

  typedef struct packed {
    logic encLoad;
    logic decLoad;
  } eccStrobeT;

  // Codeword position (1-based Hamming numbering) of information bit k:
  // the k-th position that is not a power of two.
  function automatic int infoPos(input int k);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 1; p < 1024; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == k) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/hammingParity.sv
module hammingParity #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic [(LANES-1)*(LANE_W-1)+LANE_W-1:0] info,
  output logic [LANES-3:0]                       par
);
  import weightEccPkg::*;

  localparam int INFO_W = (LANES-1)*(LANE_W-1) + LANE_W;
  localparam int PB     = LANES - 2;

  function automatic logic [INFO_W-1:0] colMask(input int j);
    logic [INFO_W-1:0] m;
    for (int k = 0; k < INFO_W; k++) m[k] = ((infoPos(k) >> j) & 1) == 1;
    return m;
  endfunction

  for (genvar j = 0; j < PB; j++) begin : gPar
    localparam logic [INFO_W-1:0] MASK = colMask(j);
    assign par[j] = ^(info & MASK);
  end

endmodule

// File: rtl/eccControl.sv
module eccControl (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   encValidIn,
  input  logic                   decValidIn,
  output weightEccPkg::eccStrobeT strb,
  output logic                   encValidOut,
  output logic                   decValidOut
);

  always_comb begin
    strb.encLoad = encValidIn;
    strb.decLoad = decValidIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encValidOut <= 1'b0;
      decValidOut <= 1'b0;
    end else begin
      encValidOut <= encValidIn;
      decValidOut <= decValidIn;
    end
  end

endmodule

// File: rtl/eccDatapath.sv
module eccDatapath #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  weightEccPkg::eccStrobeT strb,
  input  logic [LANES*LANE_W-1:0] encWeights,
  input  logic [LANES*LANE_W-1:0] decWord,
  output logic [LANES*LANE_W-1:0] encWord,
  output logic                    encRange,
  output logic [LANES*LANE_W-1:0] decWeights,
  output logic                    decCorr,
  output logic                    decUnc
);
  import weightEccPkg::*;

  localparam int RW     = LANE_W - 1;                 // kept bits in a narrow lane
  localparam int WORD_W = LANES * LANE_W;
  localparam int NARROW = LANES - 1;                  // lanes giving up a bit
  localparam int PB     = NARROW - 1;                 // Hamming bits
  localparam int INFO_W = NARROW * RW + LANE_W;
  localparam int TOP    = NARROW * LANE_W;            // lsb of the full lane

  function automatic logic [INFO_W-1:0] getInfo(input logic [WORD_W-1:0] v);
    logic [INFO_W-1:0] r;
    for (int i = 0; i < NARROW; i++) r[i*RW +: RW] = v[i*LANE_W +: RW];
    r[NARROW*RW +: LANE_W] = v[TOP +: LANE_W];
    return r;
  endfunction

  // ---------------- encode ----------------
  logic [INFO_W-1:0] encInfo;
  logic [PB-1:0]     encPar;
  logic              encOverall;
  logic [WORD_W-1:0] encWordNext;
  logic              encRangeNext;

  assign encInfo = getInfo(encWeights);

  hammingParity #(.LANES(LANES), .LANE_W(LANE_W)) encParity_i (
    .info (encInfo),
    .par  (encPar)
  );

  assign encOverall = ^{encInfo, encPar};

  always_comb begin
    logic [NARROW-1:0] chk;
    chk = {encOverall, encPar};
    encRangeNext = 1'b0;
    for (int i = 0; i < NARROW; i++) begin
      encWordNext[i*LANE_W +: LANE_W] = {chk[i], encWeights[i*LANE_W +: RW]};
      encRangeNext = encRangeNext | (encWeights[i*LANE_W+RW] ^ encWeights[i*LANE_W+RW-1]);
    end
    encWordNext[TOP +: LANE_W] = encWeights[TOP +: LANE_W];
  end

  // ---------------- decode ----------------
  logic [INFO_W-1:0] decInfo;
  logic [PB-1:0]     decPar;
  logic [PB-1:0]     storedPar;
  logic [PB-1:0]     syndrome;
  logic              oddParity;
  logic [INFO_W-1:0] flipMask;
  logic [INFO_W-1:0] fixedInfo;
  logic [WORD_W-1:0] decWeightsNext;
  logic              decCorrNext;
  logic              decUncNext;

  assign decInfo = getInfo(decWord);

  hammingParity #(.LANES(LANES), .LANE_W(LANE_W)) decParity_i (
    .info (decInfo),
    .par  (decPar)
  );

  for (genvar j = 0; j < PB; j++) begin : gStored
    assign storedPar[j] = decWord[j*LANE_W + RW];
  end

  assign syndrome  = decPar ^ storedPar;
  assign oddParity = ^decWord;

  // A data bit is flipped only when the syndrome names its position and
  // the overall parity marks an odd number of errors.
  for (genvar k = 0; k < INFO_W; k++) begin : gFlip
    localparam logic [PB-1:0] POS = PB'(infoPos(k));
    assign flipMask[k] = oddParity && (syndrome == POS);
  end

  assign fixedInfo   = decInfo ^ flipMask;
  assign decCorrNext = oddParity;
  assign decUncNext  = !oddParity && (syndrome != '0);

  always_comb begin
    for (int i = 0; i < NARROW; i++)
      decWeightsNext[i*LANE_W +: LANE_W] = {fixedInfo[i*RW+RW-1], fixedInfo[i*RW +: RW]};
    decWeightsNext[TOP +: LANE_W] = fixedInfo[NARROW*RW +: LANE_W];
  end

  // ---------------- output registers ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      encWord  <= '0;
      encRange <= 1'b0;
    end else if (strb.encLoad) begin
      encWord  <= encWordNext;
      encRange <= encRangeNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decWeights <= '0;
      decCorr    <= 1'b0;
      decUnc     <= 1'b0;
    end else if (strb.decLoad) begin
      decWeights <= decWeightsNext;
      decCorr    <= decCorrNext;
      decUnc     <= decUncNext;
    end
  end

endmodule

// File: rtl/weightGroupEcc.sv
module weightGroupEcc #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    encValidIn,
  input  logic [LANES*LANE_W-1:0] encWeightsIn,
  output logic                    encValidOut,
  output logic [LANES*LANE_W-1:0] encWordOut,
  output logic                    encRangeErr,
  input  logic                    decValidIn,
  input  logic [LANES*LANE_W-1:0] decWordIn,
  output logic                    decValidOut,
  output logic [LANES*LANE_W-1:0] decWeightsOut,
  output logic                    decCorrected,
  output logic                    decUncorrectable
);
  import weightEccPkg::*;

  eccStrobeT strb;

  eccControl control_i (
    .clk         (clk),
    .rstN        (rstN),
    .encValidIn  (encValidIn),
    .decValidIn  (decValidIn),
    .strb        (strb),
    .encValidOut (encValidOut),
    .decValidOut (decValidOut)
  );

  eccDatapath #(.LANES(LANES), .LANE_W(LANE_W)) datapath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .encWeights (encWeightsIn),
    .decWord    (decWordIn),
    .encWord    (encWordOut),
    .encRange   (encRangeErr),
    .decWeights (decWeightsOut),
    .decCorr    (decCorrected),
    .decUnc     (decUncorrectable)
  );

endmodule

// File: rtl/weightGroupEccChk.sv
module weightGroupEccChk #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    encValidIn,
  input logic [LANES*LANE_W-1:0] encWeightsIn,
  input logic                    encValidOut,
  input logic [LANES*LANE_W-1:0] encWordOut,
  input logic                    encRangeErr,
  input logic                    decValidIn,
  input logic                    decValidOut,
  input logic [LANES*LANE_W-1:0] decWeightsOut,
  input logic                    decCorrected,
  input logic                    decUncorrectable
);
  localparam int TOP = (LANES-1) * LANE_W;

  AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    encValidIn |=> encValidOut); // R1
  AST_ENC_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !encValidIn |=> !encValidOut); // R1
  AST_TOP_LANE_VERBATIM: assert property (@(posedge clk) disable iff (!rstN)
    encValidIn |=> encWordOut[TOP +: LANE_W] == $past(encWeightsIn[TOP +: LANE_W])); // R2
  AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    encValidOut |-> !(^encWordOut)); // R3
  AST_TOP_LANE_NO_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (encValidIn && $countones(encWeightsIn[TOP-1:0] ^ (encWeightsIn[TOP-1:0] << 1) & {(LANES-1){1'b1, {(LANE_W-1){1'b0}}}}) == 0)
      |=> !encRangeErr); // R4
  AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    decValidIn |=> decValidOut); // R5
  AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !encValidIn |=> $stable(encWordOut) && $stable(encRangeErr)); // R10
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !decValidIn |=> $stable(decWeightsOut) && $stable(decCorrected)); // R10
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(decCorrected && decUncorrectable)); // R11

  for (genvar i = 0; i < LANES-1; i++) begin : gSignExt
    AST_DEC_SIGN_EXT: assert property (@(posedge clk) disable iff (!rstN)
      decValidOut |-> decWeightsOut[i*LANE_W + LANE_W-1] == decWeightsOut[i*LANE_W + LANE_W-2]); // R8
  end

endmodule

bind weightGroupEcc weightGroupEccChk #(.LANES(LANES), .LANE_W(LANE_W)) chk_i (
  .clk              (clk),
  .rstN             (rstN),
  .encValidIn       (encValidIn),
  .encWeightsIn     (encWeightsIn),
  .encValidOut      (encValidOut),
  .encWordOut       (encWordOut),
  .encRangeErr      (encRangeErr),
  .decValidIn       (decValidIn),
  .decValidOut      (decValidOut),
  .decWeightsOut    (decWeightsOut),
  .decCorrected     (decCorrected),
  .decUncorrectable (decUncorrectable)
);

// File: tb/weightGroupEcc_tb_top.sv
`timescale 1ns/1ps
module weightGroupEcc_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        encValidIn = 1'b0;
  logic [63:0] encWeightsIn = '0;
  logic        encValidOut;
  logic [63:0] encWordOut;
  logic        encRangeErr;
  logic        decValidIn = 1'b0;
  logic [63:0] decWordIn = '0;
  logic        decValidOut;
  logic [63:0] decWeightsOut;
  logic        decCorrected;
  logic        decUncorrectable;

  int nTests = 0;
  int nFails = 0;

  always #10 clk = ~clk;

  weightGroupEcc dut_i (
    .clk(clk), .rstN(rstN),
    .encValidIn(encValidIn), .encWeightsIn(encWeightsIn),
    .encValidOut(encValidOut), .encWordOut(encWordOut), .encRangeErr(encRangeErr),
    .decValidIn(decValidIn), .decWordIn(decWordIn),
    .decValidOut(decValidOut), .decWeightsOut(decWeightsOut),
    .decCorrected(decCorrected), .decUncorrectable(decUncorrectable)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Weights with lanes 0..6 inside [-64,63]
  function automatic logic [63:0] makeWeights(input int seed, input logic [7:0] top);
    logic [63:0] w;
    for (int i = 0; i < 7; i++) begin
      int v;
      v = ((seed * 37 + i * 53 + seed * i * 11) % 128) - 64;
      w[i*8 +: 8] = 8'(v);
    end
    w[63:56] = top;
    return w;
  endfunction

  task automatic encodeOnce(input logic [63:0] w, output logic [63:0] word, output logic rng, output logic vld);
    @(negedge clk);
    encValidIn = 1'b1;
    encWeightsIn = w;
    @(posedge clk);
    #1;
    word = encWordOut; rng = encRangeErr; vld = encValidOut;
    @(negedge clk);
    encValidIn = 1'b0;
  endtask

  task automatic decodeOnce(input logic [63:0] word, output logic [63:0] w, output logic corr, output logic unc, output logic vld);
    @(negedge clk);
    decValidIn = 1'b1;
    decWordIn = word;
    @(posedge clk);
    #1;
    w = decWeightsOut; corr = decCorrected; unc = decUncorrectable; vld = decValidOut;
    @(negedge clk);
    decValidIn = 1'b0;
  endtask

  task automatic testReset();
    check(encValidOut == 1'b0 && decValidOut == 1'b0, "R9 valids", {62'b0, encValidOut, decValidOut}, 64'h0);
    check(encWordOut == '0 && decWeightsOut == '0, "R9 data", encWordOut | decWeightsOut, 64'h0);
    check(!encRangeErr && !decCorrected && !decUncorrectable, "R9 flags",
          {61'b0, encRangeErr, decCorrected, decUncorrectable}, 64'h0);
  endtask

  task automatic testEncodeLayout(input logic [63:0] w);
    logic [63:0] word; logic rng, vld;
    encodeOnce(w, word, rng, vld);
    check(vld, "R1 valid one cycle later", {63'b0, vld}, 64'h1);
    check(word[63:56] == w[63:56], "R2 lane7 verbatim", {56'b0, word[63:56]}, {56'b0, w[63:56]});
    for (int i = 0; i < 7; i++)
      check(word[i*8 +: 7] == w[i*8 +: 7], "R2 narrow lane low bits", {57'b0, word[i*8 +: 7]}, {57'b0, w[i*8 +: 7]});
    check(!(^word), "R3 even parity", {63'b0, ^word}, 64'h0);
    check(!rng, "R4 in-range no flag", {63'b0, rng}, 64'h0);
    @(posedge clk); #1;
    check(!encValidOut, "R1 valid drops", {63'b0, encValidOut}, 64'h0);
  endtask

  task automatic testRange();
    logic [63:0] word; logic rng, vld;
    logic [63:0] w;
    w = makeWeights(3, 8'h80);
    w[7:0] = 8'h3F; w[15:8] = 8'hC0;                 // 63 and -64: boundaries in range
    encodeOnce(w, word, rng, vld);
    check(!rng, "R4 boundaries 63/-64 accepted", {63'b0, rng}, 64'h0);
    w[63:56] = 8'h7F;
    encodeOnce(w, word, rng, vld);
    check(!rng, "R4 lane7 full range never flags", {63'b0, rng}, 64'h0);
    w[31:24] = 8'h40;                                 // 64
    encodeOnce(w, word, rng, vld);
    check(rng, "R4 lane3 = 64 flagged", {63'b0, rng}, 64'h1);
    w[31:24] = 8'h10; w[7:0] = 8'hBF;                 // -65 in lane 0
    encodeOnce(w, word, rng, vld);
    check(rng, "R4 lane0 = -65 flagged", {63'b0, rng}, 64'h1);
    w[7:0] = 8'h00; w[55:48] = 8'h80;                 // -128 in lane 6
    encodeOnce(w, word, rng, vld);
    check(rng, "R4 lane6 = -128 flagged", {63'b0, rng}, 64'h1);
  endtask

  task automatic testHold();
    logic [63:0] word; logic rng, vld;
    logic [63:0] w, d; logic corr, unc;
    w = makeWeights(9, 8'h55);
    encodeOnce(w, word, rng, vld);
    decodeOnce(word, d, corr, unc, vld);
    @(negedge clk);
    encWeightsIn = ~w;
    decWordIn = ~word;
    @(posedge clk); #1;
    check(encWordOut == word, "R10 encoder holds", encWordOut, word);
    check(decWeightsOut == w, "R10 decoder holds", decWeightsOut, w);
  endtask

  task automatic testSingleFlips(input logic [63:0] w);
    logic [63:0] word, d; logic rng, vld, corr, unc;
    encodeOnce(w, word, rng, vld);
    decodeOnce(word, d, corr, unc, vld);
    check(vld, "R5 decode valid", {63'b0, vld}, 64'h1);
    check(d == w, "R5 clean round trip", d, w);
    check(!corr && !unc, "R5 clean flags", {62'b0, corr, unc}, 64'h0);
    for (int p = 0; p < 64; p++) begin
      decodeOnce(word ^ (64'h1 << p), d, corr, unc, vld);
      check(d == w, "R6 single flip corrected", d, w);
      check(corr && !unc, "R6 single flip flags", {62'b0, corr, unc}, 64'h2);
      for (int i = 0; i < 7; i++)
        check(d[i*8+7] == d[i*8+6], "R8 sign extension", {56'b0, d[i*8 +: 8]}, {56'b0, w[i*8 +: 8]});
    end
  endtask

  task automatic testDoubleFlips(input logic [63:0] w);
    logic [63:0] word, d; logic rng, vld, corr, unc;
    encodeOnce(w, word, rng, vld);
    for (int k = 0; k < 48; k++) begin
      int a, b;
      a = (k * 7) % 64;
      b = (k * 13 + 5) % 64;
      if (a == b) b = (b + 1) % 64;
      decodeOnce(word ^ (64'h1 << a) ^ (64'h1 << b), d, corr, unc, vld);
      check(unc && !corr, "R7 double flip detected", {62'b0, corr, unc}, 64'h1);
      check(!(unc && corr), "R11 flags exclusive", {62'b0, corr, unc}, 64'h1);
    end
  endtask

  initial begin
    #(20 * 200000);
    nFails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    testReset();
    testEncodeLayout(makeWeights(1, 8'h80));
    testEncodeLayout(makeWeights(2, 8'h7F));
    testEncodeLayout(64'h0);
    testRange();
    testHold();
    testSingleFlips(makeWeights(4, 8'hA5));
    testSingleFlips(64'h0);
    testSingleFlips({8'h80, 56'hC0C0_C0C0_C0C0_C0} | 64'h0);
    testDoubleFlips(makeWeights(5, 8'h3C));
    testDoubleFlips({8'hFF, 56'h3F3F_3F3F_3F3F_3F});
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule